// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block moves outgoing frames from memory to a byte-wide frame output. It does this by walking a circular ring of 16-byte descriptors. Software fills descriptors and hands each one to the engine by setting its ownership flag. It then writes the byte address of the slot just past the last ready descriptor into a tail register, which acts as a doorbell. For each owned descriptor, the engine reads the buffer address and buffer length. It streams the buffer bytes out with start-of-frame and end-of-frame markers. It then writes descriptor word 3 back with ownership returned and an error flag. If the descriptor asked for it, the engine also raises a completion interrupt.

A frame may span several consecutive descriptors. The first-segment flag opens a frame and the last-segment flag closes it. The memory side is a single-outstanding word port: a request with a grant, and read data returned later with a valid strobe. Registers are written through a simple word-wide write strobe and read back combinationally.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset, the current-pointer register reads 0, `irq` is 0, `out_valid` is 0 and `mem_req` is 0.
- R2: Register map by `reg_addr`:
  - 0 = control (bit 0 start)
  - 1 = ring base byte address
  - 2 = descriptor count minus one
  - 3 = tail byte address
  - 4 = current descriptor pointer (read-only)
  - 5 = status (bit 0 completion)

  Writing the base also loads the current pointer with it, and every register reads back its value.
- R3: A descriptor is processed only when bit 31 (ownership) of its word 3 at offset 12 is set. If that bit is clear, the engine stops without advancing. It fetches again only after a tail write, even if ownership is granted meanwhile.
- R4: The buffer byte address is taken from word 0 (offset 0) and the length from word 2 bits 13:0 (offset 8). The bytes are sent in address order at any alignment, little-endian within each memory word. Word 1 is never read.
- R5: Word 3 bit 29 (first segment) marks the first byte sent with `out_sof`, and bit 28 (last segment) marks the final byte with `out_eof`. A frame spread over several descriptors carries exactly one of each.
- R6: Word 3 is written back only after the descriptor's last byte has been accepted. The written word has bit 31 cleared and all other bits preserved, except bit 15.
- R7: Bit 15 of the written-back word 3 is the error flag. It is set, and no byte is sent, when the length is zero, when a first-segment flag appears inside an open frame, or when it is missing outside one.
- R8: Word 2 bit 31 (completion request) sets status bit 0 and `irq` once that descriptor is done. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R9: After the slot whose index equals the count register, the pointer returns to the base.
- R10: Fetching stops when the current pointer equals the tail, with no further memory requests.
- R11: While control bit 0 is clear, no new descriptor is started. Setting it resumes from the current pointer.
- R12: `mem_req` with its address and direction holds until `mem_gnt`, and `out_valid` with its byte and markers holds until `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| irq | output | 1 | Completion interrupt (status bit 0) |

## Verification
The bench builds the block with its default 32-bit addresses and an 8-bit count register. It programs a four-slot ring, so wrap-around happens every fourth descriptor. It sweeps buffer lengths 1 to 7 against all four start alignments, which covers every first-lane and last-lane combination and frames that cross one or two word boundaries. Throughout the sweep the memory grant and the output ready are stalled in fixed and pseudo-random patterns. The small ring also makes the other cases cheap to reach: suspension on a non-owned descriptor, stopping and restarting, error writebacks, a three-descriptor frame and the completion interrupt.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int DESC_BYTES = 16;
    localparam int BLEN_W     = 14;
    localparam int OWN_BIT    = 31;
    localparam int IC_BIT     = 31;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_BASE = 3'd1,
        REG_RLEN = 3'd2,
        REG_TAIL = 3'd3,
        REG_CUR  = 3'd4,
        REG_STAT = 3'd5
    } reg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_CHECK,
        ST_DAT_REQ, ST_DAT_WAIT, ST_DAT_OUT, ST_WB, ST_NEXT
    } seq_st_e;

    typedef enum logic [1:0] {
        W_FLAGS, W_ADDR, W_CTRL
    } word_sel_e;

    typedef struct packed {
        logic        own;
        logic        rsv;
        logic        fs;
        logic        ls;
        logic [11:0] hi;
        logic        es;
        logic [14:0] tot;
    } w3_t;

    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[{lane, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int RL_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [2:0]      addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    input  logic [AW-1:0]   cur_ptr,
    input  logic            irq_set,
    output logic            run,
    output logic [AW-1:0]   base,
    output logic [RL_W-1:0] rlen,
    output logic [AW-1:0]   tail,
    output logic            base_wr,
    output logic            tail_wr,
    output logic            irq
);

    assign base_wr = wr_en && (addr == REG_BASE);
    assign tail_wr = wr_en && (addr == REG_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            base <= '0;
            rlen <= '0;
            tail <= '0;
            irq  <= 1'b0;
        end else begin
            if (wr_en && addr == REG_CTRL) run  <= wdata[0];
            if (base_wr)                   base <= wdata[AW-1:0];
            if (wr_en && addr == REG_RLEN) rlen <= wdata[RL_W-1:0];
            if (tail_wr)                   tail <= wdata[AW-1:0];
            if (irq_set)
                irq <= 1'b1;
            else if (wr_en && addr == REG_STAT && wdata[0])
                irq <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            REG_CTRL: rdata = {31'b0, run};
            REG_BASE: rdata = 32'(base);
            REG_RLEN: rdata = 32'(rlen);
            REG_TAIL: rdata = 32'(tail);
            REG_CUR:  rdata = 32'(cur_ptr);
            REG_STAT: rdata = {31'b0, irq};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/txr_ring_walker.sv
module txr_ring_walker
    import txr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int RL_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   base_new,
    input  logic            base_wr,
    input  logic [RL_W-1:0] rlen,
    input  logic [AW-1:0]   tail,
    input  logic            tail_wr,
    input  logic            adv,
    input  logic            susp_set,
    output logic [AW-1:0]   cur,
    output logic            pending
);

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    logic [RL_W-1:0] idx;
    logic            susp;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            idx  <= '0;
            susp <= 1'b0;
        end else begin
            if (base_wr) begin
                cur <= base_new;
                idx <= '0;
            end else if (adv) begin
                if (idx == rlen) begin
                    cur <= base;
                    idx <= '0;
                end else begin
                    cur <= cur + STEP;
                    idx <= idx + 1'b1;
                end
            end
            if (tail_wr)
                susp <= 1'b0;
            else if (susp_set)
                susp <= 1'b1;
        end
    end

    assign pending = (cur != tail) && !susp;

endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          pending,
    input  logic [AW-1:0] cur,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_sof,
    output logic          out_eof,
    output logic          adv,
    output logic          susp_set,
    output logic          irq_set
);

    seq_st_e           st;
    word_sel_e         sel;
    logic [AW-1:0]     rd_addr;
    logic [AW-1:0]     w0;
    logic              w2_ic;
    logic [BLEN_W-1:0] w2_len;
    w3_t               w3;
    w3_t               wb;
    logic              err;
    logic              in_frame;
    logic [AW-1:0]     bptr;
    logic [BLEN_W-1:0] remain;
    logic              sof_pend;
    logic [31:0]       dword;
    logic              bad;
    logic              last_byte;

    assign bad       = (w2_len == '0) || (w3.fs == in_frame);
    assign last_byte = (remain == BLEN_W'(1));

    always_comb begin
        wb     = w3;
        wb.own = 1'b0;
        wb.es  = err;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rd_addr;
        mem_wdata = wb;
        case (st)
            ST_RD_REQ:  mem_req = 1'b1;
            ST_DAT_REQ: begin
                mem_req  = 1'b1;
                mem_addr = {bptr[AW-1:2], 2'b00};
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur + AW'(12);
            end
            default: ;
        endcase
    end

    assign out_valid = (st == ST_DAT_OUT);
    assign out_data  = pick_byte(dword, bptr[1:0]);
    assign out_sof   = out_valid && sof_pend;
    assign out_eof   = out_valid && w3.ls && last_byte;

    assign adv      = (st == ST_NEXT);
    assign irq_set  = (st == ST_NEXT) && w2_ic;
    assign susp_set = (st == ST_RD_WAIT) && mem_rvalid && (sel == W_FLAGS) && !mem_rdata[OWN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            sel      <= W_FLAGS;
            rd_addr  <= '0;
            w0       <= '0;
            w2_ic    <= 1'b0;
            w2_len   <= '0;
            w3       <= '0;
            err      <= 1'b0;
            in_frame <= 1'b0;
            bptr     <= '0;
            remain   <= '0;
            sof_pend <= 1'b0;
            dword    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (run && pending) begin
                    rd_addr <= cur + AW'(12);
                    sel     <= W_FLAGS;
                    st      <= ST_RD_REQ;
                end
                ST_RD_REQ: if (mem_gnt) st <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rvalid) begin
                    case (sel)
                        W_FLAGS: begin
                            w3 <= w3_t'(mem_rdata);
                            if (mem_rdata[OWN_BIT]) begin
                                sel     <= W_ADDR;
                                rd_addr <= cur;
                                st      <= ST_RD_REQ;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        W_ADDR: begin
                            w0      <= mem_rdata[AW-1:0];
                            sel     <= W_CTRL;
                            rd_addr <= cur + AW'(8);
                            st      <= ST_RD_REQ;
                        end
                        default: begin
                            w2_ic  <= mem_rdata[IC_BIT];
                            w2_len <= mem_rdata[BLEN_W-1:0];
                            st     <= ST_CHECK;
                        end
                    endcase
                end
                ST_CHECK: begin
                    if (bad) begin
                        err      <= 1'b1;
                        in_frame <= 1'b0;
                        st       <= ST_WB;
                    end else begin
                        err      <= 1'b0;
                        in_frame <= !w3.ls;
                        bptr     <= w0;
                        remain   <= w2_len;
                        sof_pend <= w3.fs;
                        st       <= ST_DAT_REQ;
                    end
                end
                ST_DAT_REQ: if (mem_gnt) st <= ST_DAT_WAIT;
                ST_DAT_WAIT: if (mem_rvalid) begin
                    dword <= mem_rdata;
                    st    <= ST_DAT_OUT;
                end
                ST_DAT_OUT: if (out_ready) begin
                    bptr     <= bptr + AW'(1);
                    remain   <= remain - BLEN_W'(1);
                    sof_pend <= 1'b0;
                    if (last_byte)
                        st <= ST_WB;
                    else if (bptr[1:0] == 2'b11)
                        st <= ST_DAT_REQ;
                end
                ST_WB: if (mem_gnt) st <= ST_NEXT;
                ST_NEXT: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
    import txr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int RL_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_sof,
    output logic          out_eof,
    output logic          irq
);

    logic            run;
    logic [AW-1:0]   base;
    logic [RL_W-1:0] rlen;
    logic [AW-1:0]   tail;
    logic            base_wr;
    logic            tail_wr;
    logic [AW-1:0]   cur_ptr;
    logic            pending;
    logic            adv;
    logic            susp_set;
    logic            irq_set_w;

    txr_regs #(.AW(AW), .RL_W(RL_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cur_ptr(cur_ptr),
        .irq_set(irq_set_w), .run(run), .base(base), .rlen(rlen),
        .tail(tail), .base_wr(base_wr), .tail_wr(tail_wr), .irq(irq)
    );

    txr_ring_walker #(.AW(AW), .RL_W(RL_W)) walk_i (
        .clk(clk), .rst(rst), .base(base), .base_new(reg_wdata[AW-1:0]),
        .base_wr(base_wr), .rlen(rlen), .tail(tail), .tail_wr(tail_wr),
        .adv(adv), .susp_set(susp_set), .cur(cur_ptr), .pending(pending)
    );

    txr_seq #(.AW(AW)) seq_i (
        .clk(clk), .rst(rst), .run(run), .pending(pending), .cur(cur_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .adv(adv), .susp_set(susp_set), .irq_set(irq_set_w)
    );

endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_sof,
    input logic          out_eof,
    input logic          irq,
    input logic          reg_wr_en,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          irq_set
);

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)); // R12

    AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[31]); // R6

    AST_IRQ_W1C: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && reg_addr == 3'd5 && reg_wdata[0] && !irq_set |=> !irq); // R8

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> irq); // R8

endmodule

bind tx_ring_dma txr_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .irq(irq), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_set(irq_set_w)
);

// File: tb/tx_ring_dma_tb.sv
module tx_ring_dma_tb_top;

    localparam logic [2:0] A_CTRL = 3'd0, A_BASE = 3'd1, A_RLEN = 3'd2,
                           A_TAIL = 3'd3, A_CUR = 3'd4, A_STAT = 3'd5;
    localparam logic [31:0] RING = 32'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        out_valid, out_sof, out_eof, irq;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;

    tx_ring_dma dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .irq(irq)
    );

    always #2ns clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [31:0] dmem [0:255];
    logic        bk_we = 1'b0;
    logic [31:0] bk_addr = 32'd0;
    logic [31:0] bk_data = 32'd0;
    logic [7:0]  rx_d [0:1023];
    bit          rx_s [0:1023];
    bit          rx_e [0:1023];
    int          rx_n = 0;
    int          req_cycles = 0;
    logic [7:0]  lfsr = 8'h5a;
    int          gcnt = 0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return 8'((a * 7 + 3) & 32'hff);
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (w >= 32'h200)
            return {pat(w + 3), pat(w + 2), pat(w + 1), pat(w)};
        return dmem[a[9:2]];
    endfunction

    // memory model and output collector
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (bk_we) dmem[bk_addr[9:2]] <= bk_data;
        if (mem_req && mem_gnt) begin
            if (mem_we) dmem[mem_addr[9:2]] <= mem_wdata;
            else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd_word(mem_addr);
            end
        end
        if (mem_req) req_cycles <= req_cycles + 1;
        if (out_valid && out_ready && rx_n < 1024) begin
            rx_d[rx_n] <= out_data;
            rx_s[rx_n] <= out_sof;
            rx_e[rx_n] <= out_eof;
            rx_n <= rx_n + 1;
        end
    end

    // stall patterns for grant and ready
    always @(negedge clk) begin
        gcnt    <= gcnt + 1;
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt <= (gcnt % 3) != 1;
        out_ready <= lfsr[0] | lfsr[2];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1ns;
        v = reg_rdata;
    endtask

    task automatic bwr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bk_we = 1'b1; bk_addr = a; bk_data = d;
        @(negedge clk);
        bk_we = 1'b0;
    endtask

    function automatic logic [31:0] slot_addr(input int s);
        return RING + 32'((s % 4) * 16);
    endfunction

    function automatic logic [31:0] mk_w3(input bit own, input bit fs, input bit ls, input int tot);
        return {own, 1'b0, fs, ls, 12'b0, 1'b0, 15'(tot)};
    endfunction

    task automatic post(input int s, input logic [31:0] b, input int len, input int tot,
                        input bit fs, input bit ls, input bit ic, input bit own);
        logic [31:0] da;
        da = slot_addr(s);
        bwr(da, b);
        bwr(da + 4, 32'hdead_0000);
        bwr(da + 8, {ic, 17'b0, 14'(len)});
        bwr(da + 12, mk_w3(own, fs, ls, tot));
    endtask

    task automatic wait_cur(input logic [31:0] target);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(A_CUR, v);
            if (v == target) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic check_single(input int start, input logic [31:0] b, input int len, input string tag);
        bit ok;
        ok = (rx_n - start == len);
        for (int k = 0; k < len && ok; k++) begin
            if (rx_d[start + k] != pat(b + 32'(k))) ok = 1'b0;
            if (rx_s[start + k] != (k == 0)) ok = 1'b0;
            if (rx_e[start + k] != (k == len - 1)) ok = 1'b0;
        end
        check(ok, tag, 32'(rx_n - start), 32'(len));
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int slot, start, rq;
        logic [31:0] b;
        logic [31:0] ba [0:2];
        int la [0:2];
        bit ok;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(A_CUR, v);
        check(v == 0, "R1 current pointer after reset", v, 0);
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);

        // R2 register programming
        wr_reg(A_RLEN, 32'd3);
        wr_reg(A_BASE, RING);
        rd_reg(A_CUR, v);
        check(v == RING, "R2 base write loads current pointer", v, RING);
        rd_reg(A_RLEN, v);
        check(v == 3, "R2 count readback", v, 3);
        wr_reg(A_CTRL, 32'd1);
        rd_reg(A_CTRL, v);
        check(v == 1, "R2 control readback", v, 1);

        // R4 R5 R6 R9 R12 sweep: lengths 1..7 x alignment 0..3
        slot = 0;
        for (int len = 1; len <= 7; len++) begin
            for (int al = 0; al < 4; al++) begin
                b = 32'h200 + 32'(len * 32 + al);
                start = rx_n;
                post(slot, b, len, len, 1'b1, 1'b1, 1'b0, 1'b1);
                wr_reg(A_TAIL, slot_addr(slot + 1));
                wait_cur(slot_addr(slot + 1));
                rd_reg(A_TAIL, v2);
                check(v2 == slot_addr(slot + 1), "R2 tail readback", v2, slot_addr(slot + 1));
                check_single(start, b, len, "R4 R5 R12 single-segment bytes");
                v = dmem[slot_addr(slot)[9:2] + 3];
                check(v == mk_w3(1'b0, 1'b1, 1'b1, len), "R6 writeback word 3", v,
                      mk_w3(1'b0, 1'b1, 1'b1, len));
                slot = (slot + 1) % 4;
            end
        end
        rd_reg(A_CUR, v);
        check(v == RING, "R9 pointer wrapped to base", v, RING);
        check(irq == 1'b0, "R8 no completion request so irq low", 32'(irq), 0);

        // R10 pointer equals tail: no further requests
        rq = req_cycles;
        repeat (30) @(negedge clk);
        check(req_cycles == rq, "R10 idle at tail", 32'(req_cycles), 32'(rq));

        // R3 ownership clear: suspend, resume only after tail write
        start = rx_n;
        b = 32'h301;
        post(slot, b, 5, 5, 1'b1, 1'b1, 1'b0, 1'b0);
        wr_reg(A_TAIL, slot_addr(slot + 1));
        repeat (40) @(negedge clk);
        rd_reg(A_CUR, v);
        check(v == slot_addr(slot), "R3 no advance on non-owned descriptor", v, slot_addr(slot));
        bwr(slot_addr(slot) + 12, mk_w3(1'b1, 1'b1, 1'b1, 5));
        rq = req_cycles;
        repeat (40) @(negedge clk);
        rd_reg(A_CUR, v);
        check(v == slot_addr(slot), "R3 still suspended before tail write", v, slot_addr(slot));
        check(req_cycles == rq, "R3 no refetch before tail write", 32'(req_cycles), 32'(rq));
        wr_reg(A_TAIL, slot_addr(slot + 1));
        wait_cur(slot_addr(slot + 1));
        check_single(start, b, 5, "R3 resumed frame bytes");
        slot = (slot + 1) % 4;

        // R11 stop and restart
        wr_reg(A_CTRL, 32'd0);
        start = rx_n;
        b = 32'h342;
        post(slot, b, 4, 4, 1'b1, 1'b1, 1'b0, 1'b1);
        rq = req_cycles;
        wr_reg(A_TAIL, slot_addr(slot + 1));
        repeat (40) @(negedge clk);
        rd_reg(A_CUR, v);
        check(v == slot_addr(slot) && req_cycles == rq, "R11 stopped engine does not fetch",
              v, slot_addr(slot));
        wr_reg(A_CTRL, 32'd1);
        wait_cur(slot_addr(slot + 1));
        check_single(start, b, 4, "R11 frame after restart");
        slot = (slot + 1) % 4;

        // R7 missing first-segment flag outside a frame
        start = rx_n;
        post(slot, 32'h380, 3, 3, 1'b0, 1'b1, 1'b0, 1'b1);
        wr_reg(A_TAIL, slot_addr(slot + 1));
        wait_cur(slot_addr(slot + 1));
        check(rx_n == start, "R7 no bytes for framing error", 32'(rx_n - start), 0);
        v = dmem[slot_addr(slot)[9:2] + 3];
        check(v == (mk_w3(1'b0, 1'b0, 1'b1, 3) | 32'h8000), "R7 error flag on framing error", v,
              mk_w3(1'b0, 1'b0, 1'b1, 3) | 32'h8000);
        slot = (slot + 1) % 4;

        // R7 zero length
        start = rx_n;
        post(slot, 32'h390, 0, 0, 1'b1, 1'b1, 1'b0, 1'b1);
        wr_reg(A_TAIL, slot_addr(slot + 1));
        wait_cur(slot_addr(slot + 1));
        v = dmem[slot_addr(slot)[9:2] + 3];
        check(rx_n == start && v == (mk_w3(1'b0, 1'b1, 1'b1, 0) | 32'h8000),
              "R7 zero-length error", v, mk_w3(1'b0, 1'b1, 1'b1, 0) | 32'h8000);
        slot = (slot + 1) % 4;

        // R5 three-descriptor frame
        ba[0] = 32'h243; la[0] = 3;
        ba[1] = 32'h282; la[1] = 2;
        ba[2] = 32'h2c1; la[2] = 4;
        start = rx_n;
        post(slot,     ba[0], la[0], 9, 1'b1, 1'b0, 1'b0, 1'b1);
        post(slot + 1, ba[1], la[1], 9, 1'b0, 1'b0, 1'b0, 1'b1);
        post(slot + 2, ba[2], la[2], 9, 1'b0, 1'b1, 1'b0, 1'b1);
        wr_reg(A_TAIL, slot_addr(slot + 3));
        wait_cur(slot_addr(slot + 3));
        ok = (rx_n - start == 9);
        begin
            int p;
            p = start;
            for (int d = 0; d < 3 && ok; d++) begin
                for (int k = 0; k < la[d]; k++) begin
                    if (rx_d[p] != pat(ba[d] + 32'(k))) ok = 1'b0;
                    if (rx_s[p] != (p == start)) ok = 1'b0;
                    if (rx_e[p] != (p == start + 8)) ok = 1'b0;
                    p++;
                end
            end
        end
        check(ok, "R5 multi-descriptor frame markers and bytes", 32'(rx_n - start), 9);
        v = dmem[slot_addr(slot + 1)[9:2] + 3];
        check(v == mk_w3(1'b0, 1'b0, 1'b0, 9), "R6 middle segment writeback", v,
              mk_w3(1'b0, 1'b0, 1'b0, 9));
        slot = (slot + 3) % 4;

        // R8 completion interrupt and write-one-to-clear
        start = rx_n;
        b = 32'h3a0;
        post(slot, b, 2, 2, 1'b1, 1'b1, 1'b1, 1'b1);
        wr_reg(A_TAIL, slot_addr(slot + 1));
        wait_cur(slot_addr(slot + 1));
        check_single(start, b, 2, "R8 frame with completion request");
        rd_reg(A_STAT, v);
        check(irq == 1'b1 && v == 1, "R8 status set after completion", v, 1);
        wr_reg(A_STAT, 32'd0);
        check(irq == 1'b1, "R8 writing zero keeps status", 32'(irq), 1);
        wr_reg(A_STAT, 32'd1);
        rd_reg(A_STAT, v);
        check(irq == 1'b0 && v == 0, "R8 writing one clears status", v, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule